// File: doc/BRIEF.md
# Paged Address Extension Multiplexer

This block builds a 20-bit physical address for emulation memory. It starts from the 16-bit logical address on the CPU bus. A paging unit drives six extension lines, which stand for physical bits 13 to 18, and a program chip-select line. A 7-bit configuration mask chooses, bit by bit, whether each upper physical bit comes from the paging unit or from the plain CPU address. One mask bit decides whether the chip-select becomes physical bit 19. The CPU path is registered: a strobed bus address gives a physical address and a valid flag one cycle later.

A second, purely combinational path serves a debugger that uses 24-bit addresses.

- **Logical requests.** A debugger address below 64K is a logical address. It is translated with the live extension-line and chip-select state.
- **Direct page selection.** A debugger address of 64K or above names a page directly. Its bits 17 to 22 stand in for the extension lines and its bit 23 stands in for the chip-select.
- **Page zero.** Bit 16 lets a request for page zero be told apart from a logical address.

The window registers of the paging unit, the memory array and the bus timing lie outside this block.

Top module: `pax_mux`

## Requirements
- R1: Physical bits 12 to 0 always equal CPU address bits 12 to 0.
- R2: When mask bit i (i = 0 to 5) is 1, physical bit 13+i equals extension line i (ext_lines[i]).
- R3: When mask bit i is 0, physical bits 13 to 15 take CPU address bits 13 to 15. Physical bits 16 to 18 are 0.
- R4: When mask bit 6 is 1, physical bit 19 equals prog_cs. When mask bit 6 is 0, physical bit 19 is 0.
- R5: With an all-zero mask, phys_addr equals {4'h0, cpu_addr}, whatever the extension lines and prog_cs are.
- R6: phys_addr and phys_valid update on the rising edge at which cpu_strobe is sampled high. They are first seen in the cycle after the strobe. phys_valid is 1 only in cycles that follow a strobe cycle. Without a strobe, phys_addr holds its value.
- R7: A debugger address below 0x10000 gives dbg_phys as the same-cycle translation of dbg_addr[15:0], using the current ext_lines, prog_cs and mask.
- R8: A debugger address of 0x10000 or above uses dbg_addr[22:17] in place of ext_lines[5:0] and dbg_addr[23] in place of prog_cs. It uses dbg_addr[15:0] as the logical part, and the mask still applies.
- R9: A debugger address with bit 16 set and bits 23 to 17 clear selects page zero. Every masked upper bit is then 0, even when the extension lines are high.
- R10: While rst is high, phys_addr is 0 and phys_valid is 0 at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical CPU bus address |
| cpu_strobe | input | 1 | Address valid strobe for cpu_addr |
| ext_lines | input | 6 | Paging unit outputs for physical bits 13 to 18 |
| prog_cs | input | 1 | Program chip-select from the paging unit |
| cfg_mask | input | 7 | Bits 0 to 5 enable the extension lines; bit 6 enables prog_cs as bit 19 |
| dbg_addr | input | 24 | Debugger address |
| phys_addr | output | 20 | Registered physical address of the CPU path |
| phys_valid | output | 1 | High in the cycle after a strobed address |
| dbg_phys | output | 20 | Combinational physical address of the debugger path |

## Verification
The assertions check the following on every cycle:
- pass-through of the low thirteen bits on both paths;
- one-cycle timing of the valid flag, and holding of the address when there is no strobe;
- the zero forcing of bit 19 and of the whole upper nibble under an empty mask;
- page-zero forcing of the upper debugger bits.

The bench's scenarios cover the rest:
- which individual extension line feeds which physical bit under mixed masks;
- that clear mask bits fall back to the logical bits only for bits 13 to 15;
- that direct debugger pages override live extension lines;
- that back-to-back strobes each give a fresh result.

// File: rtl/pax_pkg.sv
package pax_pkg;
    localparam int LOG_W   = 16;
    localparam int EXT_LO  = 13;
    localparam int EXT_N   = 6;
    localparam int MASK_W  = EXT_N + 1;
    localparam int PHYS_W  = EXT_LO + EXT_N + 1;
    localparam int PAGE_LO = LOG_W + 1;
    localparam int DBG_W   = PAGE_LO + EXT_N + 1;

    typedef struct packed {
        logic             cs;
        logic [EXT_N-1:0] ext;
    } pax_page_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        pax_page_t         page;
        logic [LOG_W-1:0]  la;
    } pax_req_t;

    function automatic logic pick_bit(logic sel, logic paged, logic plain);
        return sel ? paged : plain;
    endfunction
endpackage

// File: rtl/pax_xlate.sv
module pax_xlate
    import pax_pkg::*;
(
    input  pax_req_t          req,
    output logic [PHYS_W-1:0] pa
);
    assign pa[EXT_LO-1:0] = req.la[EXT_LO-1:0];

    for (genvar i = 0; i < EXT_N; i++) begin : g_upper
        localparam int B = EXT_LO + i;
        if (B < LOG_W) begin : g_fallback_logical
            assign pa[B] = pick_bit(req.mask[i], req.page.ext[i], req.la[B]);
        end else begin : g_fallback_zero
            assign pa[B] = pick_bit(req.mask[i], req.page.ext[i], 1'b0);
        end
    end

    assign pa[PHYS_W-1] = pick_bit(req.mask[EXT_N], req.page.cs, 1'b0);
endmodule

// File: rtl/pax_dbg_src.sv
module pax_dbg_src
    import pax_pkg::*;
(
    input  logic [DBG_W-1:0] dbg_addr,
    input  pax_page_t        live_page,
    output pax_page_t        page,
    output logic [LOG_W-1:0] la
);
    logic direct;
    pax_page_t fixed_page;

    assign direct         = |dbg_addr[DBG_W-1:LOG_W];
    assign fixed_page.ext = dbg_addr[PAGE_LO+EXT_N-1:PAGE_LO];
    assign fixed_page.cs  = dbg_addr[DBG_W-1];
    assign page           = direct ? fixed_page : live_page;
    assign la             = dbg_addr[LOG_W-1:0];
endmodule

// File: rtl/pax_out_reg.sv
module pax_out_reg
    import pax_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [PHYS_W-1:0] pa_in,
    output logic [PHYS_W-1:0] pa_q,
    output logic              valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= strobe;
            if (strobe) pa_q <= pa_in;
        end
    end

    // R6: the flag follows the strobe by one cycle
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> valid_q);
    // R6: without a strobe, the flag drops and the address holds
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (!valid_q && $stable(pa_q)));
    // R6: a strobe loads the address that was presented with it
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (pa_q == $past(pa_in)));
endmodule

// File: rtl/pax_mux.sv
module pax_mux
    import pax_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  cpu_addr,
    input  logic              cpu_strobe,
    input  logic [EXT_N-1:0]  ext_lines,
    input  logic              prog_cs,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [DBG_W-1:0]  dbg_addr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              phys_valid,
    output logic [PHYS_W-1:0] dbg_phys
);
    pax_page_t         live_page;
    pax_page_t         dbg_page;
    logic [LOG_W-1:0]  dbg_la;
    pax_req_t          cpu_req;
    pax_req_t          dbg_req;
    logic [PHYS_W-1:0] cpu_pa;

    assign live_page.ext = ext_lines;
    assign live_page.cs  = prog_cs;

    assign cpu_req.mask = cfg_mask;
    assign cpu_req.page = live_page;
    assign cpu_req.la   = cpu_addr;

    pax_dbg_src u_src (
        .dbg_addr (dbg_addr),
        .live_page(live_page),
        .page     (dbg_page),
        .la       (dbg_la)
    );

    assign dbg_req.mask = cfg_mask;
    assign dbg_req.page = dbg_page;
    assign dbg_req.la   = dbg_la;

    pax_xlate u_xl_cpu (.req(cpu_req), .pa(cpu_pa));
    pax_xlate u_xl_dbg (.req(dbg_req), .pa(dbg_phys));

    pax_out_reg u_oreg (
        .clk    (clk),
        .rst    (rst),
        .strobe (cpu_strobe),
        .pa_in  (cpu_pa),
        .pa_q   (phys_addr),
        .valid_q(phys_valid)
    );

    // R1: the low bits of a registered result come from the strobed CPU address
    p_low_pass_r1: assert property (@(posedge clk) disable iff (rst)
        phys_valid |-> (phys_addr[EXT_LO-1:0] == $past(cpu_addr[EXT_LO-1:0])));
    // R5: an empty mask gives plain 16-bit pass-through
    p_empty_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (phys_valid && ($past(cfg_mask) == '0)) |->
        (phys_addr == {{(PHYS_W-LOG_W){1'b0}}, $past(cpu_addr)}));
    // R4: bit 19 stays low unless its mask bit was set
    p_cs_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (phys_valid && !$past(cfg_mask[EXT_N])) |-> !phys_addr[PHYS_W-1]);
    // R2: an enabled first extension line reaches bit 13
    p_ext0_r2: assert property (@(posedge clk) disable iff (rst)
        (phys_valid && $past(cfg_mask[0])) |-> (phys_addr[EXT_LO] == $past(ext_lines[0])));
    // R7: the low bits of the debugger path pass straight through
    p_dbg_low_r7: assert property (@(posedge clk) disable iff (rst)
        dbg_phys[EXT_LO-1:0] == dbg_addr[EXT_LO-1:0]);
    // R9: a page-zero request clears the upper physical bits
    p_page_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr[DBG_W-1:LOG_W] == 8'h01) |-> (dbg_phys[PHYS_W-1:LOG_W] == '0));
endmodule

// File: tb/sim_pax_mux.sv
module sim_pax_mux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_strobe = 1'b0;
    logic [5:0]  ext_lines = '0;
    logic        prog_cs = 1'b0;
    logic [6:0]  cfg_mask = '0;
    logic [23:0] dbg_addr = '0;
    logic [19:0] phys_addr;
    logic        phys_valid;
    logic [19:0] dbg_phys;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pax_mux u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_strobe(cpu_strobe),
        .ext_lines(ext_lines), .prog_cs(prog_cs), .cfg_mask(cfg_mask),
        .dbg_addr(dbg_addr), .phys_addr(phys_addr), .phys_valid(phys_valid),
        .dbg_phys(dbg_phys)
    );

    // Each entry: {mask[6:0], ext[5:0], cs, addr[15:0], expected[19:0]}
    localparam int NV = 7;
    localparam logic [49:0] VEC [NV] = '{
        {7'h00, 6'h3F, 1'b1, 16'hABCD, 20'h0ABCD},  // R5
        {7'h7F, 6'h3F, 1'b1, 16'h1234, 20'hFF234},  // R2 R4
        {7'h07, 6'h00, 1'b0, 16'hE123, 20'h00123},  // R2 R3
        {7'h38, 6'h28, 1'b1, 16'hA555, 20'h5A555},  // R3 R4
        {7'h40, 6'h3F, 1'b1, 16'h0F0F, 20'h80F0F},  // R4
        {7'h15, 6'h2A, 1'b0, 16'hFFFF, 20'h05FFF},  // R2 R3
        {7'h15, 6'h15, 1'b0, 16'hFFFF, 20'h2FFFF}   // R1 R2 R3
    };

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe_cpu(input logic [15:0] a);
        @(negedge clk);
        cpu_addr   = a;
        cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset phys_addr", phys_addr, 20'h0);
        chk("R10 reset phys_valid", {19'h0, phys_valid}, 20'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_mask, ext_lines, prog_cs, cpu_addr} = VEC[i][49:20];
            dbg_addr   = {8'h00, VEC[i][35:20]};
            cpu_strobe = 1'b1;
            #1;
            chk("R7 logical debugger address", dbg_phys, VEC[i][19:0]);
            @(negedge clk);
            cpu_strobe = 1'b0;
            chk("R1-R5 vector phys_addr", phys_addr, VEC[i][19:0]);
            chk("R6 valid after strobe", {19'h0, phys_valid}, 20'h1);
        end

        // R6: without a strobe, the address holds and the flag drops
        @(negedge clk);
        cpu_addr = 16'h5555;
        @(negedge clk);
        chk("R6 hold without strobe", phys_addr, 20'h2FFFF);
        chk("R6 valid low without strobe", {19'h0, phys_valid}, 20'h0);

        // R6: back-to-back strobes give a fresh result each cycle
        cfg_mask = 7'h00;
        @(negedge clk);
        cpu_addr = 16'h1111; cpu_strobe = 1'b1;
        @(negedge clk);
        chk("R6 first of pair", phys_addr, 20'h01111);
        cpu_addr = 16'h2222;
        @(negedge clk);
        cpu_strobe = 1'b0;
        chk("R6 second of pair", phys_addr, 20'h02222);
        chk("R6 valid stays high", {19'h0, phys_valid}, 20'h1);

        // R8: a direct page overrides the live lines
        cfg_mask = 7'h7F; ext_lines = 6'h00; prog_cs = 1'b0;
        dbg_addr = 24'hFF1234;
        #1 chk("R8 direct page", dbg_phys, 20'hFF234);
        // R8: the mask still gates a direct page
        cfg_mask = 7'h00;
        dbg_addr = 24'h7FABCD;
        #1 chk("R8 direct page under empty mask", dbg_phys, 20'h0ABCD);
        // R9: page zero clears the masked bits although the lines are high
        cfg_mask = 7'h7F; ext_lines = 6'h3F; prog_cs = 1'b1;
        dbg_addr = 24'h01F234;
        #1 chk("R9 page zero", dbg_phys, 20'h01234);
        // R7: a logical debugger address follows the live extension lines
        cfg_mask = 7'h3F; ext_lines = 6'h2A;
        dbg_addr = 24'h001111;
        #1 chk("R7 live lines", dbg_phys, 20'h55111);

        // R10: reset in mid-run clears the outputs
        strobe_cpu(16'hBEEF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset clears phys_addr", phys_addr, 20'h0);
        chk("R10 reset clears phys_valid", {19'h0, phys_valid}, 20'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule